// File: doc/BRIEF.md
# Interrupt-to-DMA request router

This block holds one routing bit for each of eight port-input interrupt causes. A set bit means that a rising edge on its cause starts a programmed DMA transfer for that channel, with no interrupt. A clear bit means that the same edge raises a normal interrupt request. Software reaches the bits over a byte-wide register bus. A mode input picks between two write methods: set-only, which is the default method with the mode input low, and plain read/write.

When a DMA transfer finishes at a transfer count of zero and the DMA side has its interrupt enabled, hardware clears the channel's routing bit. In the same step it raises the cause again as an ordinary interrupt. On that channel the next event then goes to the interrupt controller, until software routes the channel to DMA once more.

The four lowest channels can be handed to an alternate interrupt source. Each channel has its own 2-bit select code for this. The DMA engine and interrupt priority arbitration are outside this block.

Top module: `irq_dma_router`

## Requirements
- R1: A synchronous reset clears all eight routing bits, `dma_start` and `irq_req`. Bit i (i = 0..7) belongs to port-input cause 8+i.
- R2: On a rising edge of channel i's cause while bit i is 1, `dma_start[i]` pulses in the cycle after the edge is sampled, and `irq_req[i]` stays 0.
- R3: On a rising edge of channel i's cause while bit i is 0, `irq_req[i]` pulses in the cycle after the edge is sampled, and `dma_start[i]` stays 0.
- R4: With `mode_rw` = 0 (set-only), a write sets every bit where `bus_wdata` is 1. Bits where `bus_wdata` is 0 keep their value.
- R5: With `mode_rw` = 1 (read/write), a write stores `bus_wdata` into all eight bits. With `bus_we` low, no bit changes in either mode.
- R6: When `dma_done[i]` and `dma_ie[i]` are both 1 in a cycle, bit i reads 0 from the next cycle. With `dma_ie[i]` = 0, a `dma_done[i]` pulse leaves the bit unchanged.
- R7: The terminal-count case of R6 (`dma_done[i]` and `dma_ie[i]` both 1) pulses `irq_req[i]` in the next cycle.
- R8: When a terminal-count clear and a software write that sets the same bit fall in one cycle, the clear wins and the bit reads 0. This holds in both write modes.
- R9: `dma_start` and `irq_req` are single-cycle pulses. A cause held high produces only one pulse.
- R10: For channels 0 to 3, the cause is taken from `alt_evt[i]` while `alt_sel[2i+1:2i]` = 2'b10, and `port_evt[i]` is then ignored. For channels 4 to 7, the select code has no effect.
- R11: `bus_rdata` always shows the current value of the eight routing bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rw | input | 1 | Write method: 0 set-only, 1 read/write |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current routing bits |
| port_evt | input | 8 | Port-input cause levels, one per channel |
| alt_evt | input | 4 | Alternate source cause levels for channels 0 to 3 |
| alt_sel | input | 16 | 2-bit select code per channel, channel i at [2i+1:2i] |
| dma_done | input | 8 | DMA completion at transfer count zero, per channel |
| dma_ie | input | 8 | DMA-side interrupt enable, per channel |
| dma_start | output | 8 | DMA start strobe per channel |
| irq_req | output | 8 | Interrupt request pulse per channel |

## Verification
The bench sets a terminal-count pulse against a write to the same bit, once in each write mode. A design that lets the write win would leave that bit set, and would send the next event on that channel to DMA instead of the interrupt controller.

It writes zeros in set-only mode and writes with the strobe low. A design that treats set-only as plain storage would read back cleared bits.

It pulses `dma_done` with the enable off. A design that ignores the qualifier would clear the bit and raise a stray interrupt.

It holds a cause high for several cycles, and it moves shared and unshared channels onto the alternate select code. A level-sensitive router would repeat its strobe. A wrong select decode would answer the port input or the alternate input on the wrong channels.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
  typedef enum logic { WM_SET_ONLY = 1'b0, WM_READ_WRITE = 1'b1 } wmode_e;

  function automatic logic [7:0] next_bits(input wmode_e mode, input logic we,
                                           input logic [7:0] cur, input logic [7:0] wd);
    if (!we) return cur;
    return (mode == WM_SET_ONLY) ? (cur | wd) : wd;
  endfunction
endpackage

// File: rtl/idr_cause_sel.sv
module idr_cause_sel #(
  parameter int NCH = 8,
  parameter int NSHARED = 4,
  parameter int SEL_W = 2,
  parameter logic [SEL_W-1:0] ALT_CODE = 2'b10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       port_evt,
  input  logic [NSHARED-1:0]   alt_evt,
  input  logic [NCH*SEL_W-1:0] alt_sel,
  output logic [NCH-1:0]       rise
);
  logic [NCH-1:0] cause, cause_q;

  for (genvar i = 0; i < NCH; i++) begin : g_src
    if (i < NSHARED) begin : g_shared
      assign cause[i] = (alt_sel[i*SEL_W +: SEL_W] == ALT_CODE) ? alt_evt[i] : port_evt[i];
    end else begin : g_plain
      assign cause[i] = port_evt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= cause;
  end

  assign rise = cause & ~cause_q;
endmodule

// File: rtl/idr_req_reg.sv
module idr_req_reg
  import irq_dma_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_rw,
  input  logic           we,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] hw_clr,
  output logic [NCH-1:0] bits
);
  wmode_e mode;
  logic [NCH-1:0] sw_next;

  assign mode = wmode_e'(mode_rw);

  always_comb begin
    sw_next = bits;
    if (we) sw_next = (mode == WM_SET_ONLY) ? (bits | wdata) : wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) bits <= '0;
    else     bits <= sw_next & ~hw_clr;
  end
endmodule

// File: rtl/idr_pulse_out.sv
module idr_pulse_out #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] rise,
  input  logic [NCH-1:0] route_dma,
  input  logic [NCH-1:0] tc_hit,
  output logic [NCH-1:0] dma_start,
  output logic [NCH-1:0] irq_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dma_start <= '0;
      irq_req   <= '0;
    end else begin
      dma_start <= rise & route_dma;
      irq_req   <= (rise & ~route_dma) | tc_hit;
    end
  end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router #(
  parameter int NCH = 8,
  parameter int NSHARED = 4,
  parameter int SEL_W = 2,
  parameter logic [SEL_W-1:0] ALT_CODE = 2'b10,
  localparam int SELW_ALL = NCH * SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_rw,
  input  logic                bus_we,
  input  logic [NCH-1:0]      bus_wdata,
  output logic [NCH-1:0]      bus_rdata,
  input  logic [NCH-1:0]      port_evt,
  input  logic [NSHARED-1:0]  alt_evt,
  input  logic [SELW_ALL-1:0] alt_sel,
  input  logic [NCH-1:0]      dma_done,
  input  logic [NCH-1:0]      dma_ie,
  output logic [NCH-1:0]      dma_start,
  output logic [NCH-1:0]      irq_req
);
  logic [NCH-1:0] rise, bits, tc_hit;

  assign tc_hit    = dma_done & dma_ie;
  assign bus_rdata = bits;

  idr_cause_sel #(.NCH(NCH), .NSHARED(NSHARED), .SEL_W(SEL_W), .ALT_CODE(ALT_CODE)) u_sel (
    .clk(clk), .rst(rst), .port_evt(port_evt), .alt_evt(alt_evt), .alt_sel(alt_sel), .rise(rise));

  idr_req_reg #(.NCH(NCH)) u_reg (
    .clk(clk), .rst(rst), .mode_rw(mode_rw), .we(bus_we), .wdata(bus_wdata),
    .hw_clr(tc_hit), .bits(bits));

  idr_pulse_out #(.NCH(NCH)) u_out (
    .clk(clk), .rst(rst), .rise(rise), .route_dma(bits), .tc_hit(tc_hit),
    .dma_start(dma_start), .irq_req(irq_req));
endmodule

// File: rtl/idr_checker.sv
module idr_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           mode_rw,
  input logic           bus_we,
  input logic [NCH-1:0] bus_wdata,
  input logic [NCH-1:0] bus_rdata,
  input logic [NCH-1:0] dma_done,
  input logic [NCH-1:0] dma_ie,
  input logic [NCH-1:0] dma_start,
  input logic [NCH-1:0] irq_req
);
  logic [NCH-1:0] tc;
  assign tc = dma_done & dma_ie;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && dma_start == '0 && irq_req == '0));

  p_start_needs_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (dma_start & ~$past(bus_rdata)) == '0);

  p_setonly_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !mode_rw) |=> ((bus_rdata | $past(tc)) & $past(bus_wdata)) == $past(bus_wdata));

  p_setonly_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    !mode_rw |=> ($past(bus_rdata) & ~$past(tc) & ~bus_rdata) == '0);

  p_rw_store_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && mode_rw) |=> bus_rdata == ($past(bus_wdata) & ~$past(tc)));

  p_hw_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (tc != '0) |=> (bus_rdata & $past(tc)) == '0);

  p_tc_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (tc != '0) |=> (irq_req & $past(tc)) == $past(tc));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (dma_start & $past(dma_start)) == '0);
endmodule

bind irq_dma_router idr_checker #(.NCH(NCH)) u_chk (.*);

// File: tb/test_irq_dma_router.sv
module test_irq_dma_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_rw = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] port_evt = '0, dma_done = '0, dma_ie = '0, dma_start, irq_req;
  logic [3:0] alt_evt = '0;
  logic [15:0] alt_sel = '0;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_dma_router i_irq_dma_router (.*);

  // {mode_rw, bus_we, bus_wdata, expected bus_rdata}
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 1'b1, 8'h05, 8'h05},  // R4 set
    {1'b0, 1'b1, 8'h0A, 8'h0F},  // R4 set more
    {1'b0, 1'b1, 8'h00, 8'h0F},  // R4 zeros ignored
    {1'b0, 1'b1, 8'h80, 8'h8F},  // R4
    {1'b1, 1'b1, 8'h30, 8'h30},  // R5 direct store
    {1'b1, 1'b1, 8'h00, 8'h00},  // R5
    {1'b1, 1'b1, 8'hFF, 8'hFF},  // R5
    {1'b0, 1'b0, 8'h00, 8'hFF},  // R5 no strobe
    {1'b1, 1'b0, 8'h00, 8'hFF},  // R5 no strobe
    {1'b1, 1'b1, 8'h3C, 8'h3C}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 dma_start", dma_start, 8'h00);
    chk("R1 irq_req", irq_req, 8'h00);
    rst = 1'b0;
    tick();
    chk("R11 rdata after reset", bus_rdata, 8'h00);

    for (int k = 0; k < 10; k++) begin
      mode_rw = VEC[k][17]; bus_we = VEC[k][16]; bus_wdata = VEC[k][15:8];
      tick();
      bus_we = 1'b0;
      chk($sformatf("R4/R5 vector %0d", k), bus_rdata, VEC[k][7:0]);
    end

    // routing bits 0x3C: channel 2 routed to DMA
    port_evt[2] = 1'b1; tick();
    chk("R2 dma_start ch2", dma_start, 8'h04);
    chk("R2 no irq ch2", irq_req, 8'h00);
    tick();
    chk("R9 single dma pulse", dma_start, 8'h00);
    tick();
    chk("R9 held cause no repeat", dma_start | irq_req, 8'h00);
    port_evt[2] = 1'b0; tick();

    port_evt[0] = 1'b1; tick();
    chk("R3 irq ch0", irq_req, 8'h01);
    chk("R3 no dma ch0", dma_start, 8'h00);
    tick();
    chk("R9 single irq pulse", irq_req, 8'h00);
    port_evt[0] = 1'b0; tick();

    dma_done[2] = 1'b1; dma_ie[2] = 1'b1; tick();
    dma_done = '0; dma_ie = '0;
    chk("R6 tc clears bit2", bus_rdata, 8'h38);
    chk("R7 tc irq ch2", irq_req, 8'h04);
    tick();
    chk("R7 tc irq is one pulse", irq_req, 8'h00);

    dma_done[3] = 1'b1; dma_ie[3] = 1'b0; tick();
    dma_done = '0;
    chk("R6 no clear without ie", bus_rdata, 8'h38);
    chk("R6 no irq without ie", irq_req, 8'h00);

    port_evt[2] = 1'b1; tick();
    chk("R3 ch2 now interrupts", irq_req, 8'h04);
    port_evt[2] = 1'b0; tick();

    mode_rw = 1'b1; bus_we = 1'b1; bus_wdata = 8'hFF;
    dma_done[4] = 1'b1; dma_ie[4] = 1'b1; tick();
    bus_we = 1'b0; dma_done = '0; dma_ie = '0;
    chk("R8 clear beats rw write", bus_rdata, 8'hEF);
    mode_rw = 1'b0; bus_we = 1'b1; bus_wdata = 8'h10;
    dma_done[4] = 1'b1; dma_ie[4] = 1'b1; tick();
    bus_we = 1'b0; dma_done = '0; dma_ie = '0;
    chk("R8 clear beats set-only write", bus_rdata, 8'hEF);
    tick();

    alt_sel[3:2] = 2'b10; alt_sel[11:10] = 2'b10; tick();
    port_evt[1] = 1'b1; tick();
    chk("R10 port input ignored on alt ch1", dma_start | irq_req, 8'h00);
    port_evt[1] = 1'b0; tick();
    alt_evt[1] = 1'b1; tick();
    chk("R10 alt source drives ch1", dma_start, 8'h02);
    alt_evt[1] = 1'b0; tick();
    port_evt[5] = 1'b1; tick();
    chk("R10 select ignored on ch5", dma_start, 8'h20);
    port_evt[5] = 1'b0; tick();
    chk("R11 rdata final", bus_rdata, 8'hEF);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule